// File: doc/BRIEF.md
# SPI Status Flag Controller

This block holds the status register of a byte-wide SPI peripheral on a small CPU register bus. The register has three live fields: a transfer-complete flag, a write-collision flag and a read/write control bit that doubles the serial clock rate. The block watches strobes from the shift engine, the CPU's accesses to the status and data registers, the slave-select pin and the interrupt-acknowledge strobe. From these it keeps the flags and drives an interrupt request. It also tells the clock divider whether to run at double speed.

Software clears the flags in two steps. It first reads the status register while a flag is set. It then makes a later access, read or write, to the data register. Each flag remembers on its own whether a status read saw it set. A data-register access clears only the flags that were seen this way, so a flag that sets after the status read is not lost. The transfer-complete flag also clears when the CPU acknowledges its interrupt vector. It also sets on a mode fault: the block is master, slave select is an input, and that input goes low. All control and status pins are plain level or single-cycle strobe signals. No stream data passes through the block, so no valid/ready handshake or back-pressure applies.

Top module: `spi_stat_ctrl`

## Requirements
- R1: After reset, stat_rdata is 0x00, irq is 0 and speed_double is 0.
- R2: stat_rdata puts the transfer-complete flag in bit 7 and the write-collision flag in bit 6. The double-speed bit is in bit 0, and bits 5 to 1 always read 0. The CPU cannot write the two flags.
- R3: A one-cycle xfer_done pulse sets the transfer-complete flag, and the flag is visible in the next cycle.
- R4: The transfer-complete flag sets once, on the first cycle in which master_mode, ss_is_input and a low ss_n are all true together. If that condition stays true, the flag does not set again.
- R5: A data_wr while xfer_busy is 1 sets the write-collision flag. A data_wr while xfer_busy is 0 does not set it.
- R6: A stat_rd while a flag is 1 arms that flag. A later data_rd or data_wr clears every armed flag in the next cycle.
- R7: A data-register access leaves alone any flag that is 1 but was not seen by a status read since it last set.
- R8: When a set event and a clear event hit the same flag in one cycle, the flag stays 1 and is no longer armed.
- R9: An irq_ack pulse clears the transfer-complete flag. It does not change the write-collision flag.
- R10: irq is 1 exactly when the transfer-complete flag, int_en and glob_ie are all 1.
- R11: stat_wr loads wr_spd into the double-speed bit, which holds between writes. speed_double equals that bit ANDed with master_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_rd | input | 1 | CPU read strobe for the status register |
| stat_wr | input | 1 | CPU write strobe for the status register |
| wr_spd | input | 1 | Write data for the double-speed bit (bus bit 0) |
| data_rd | input | 1 | CPU read strobe for the data register |
| data_wr | input | 1 | CPU write strobe for the data register |
| xfer_busy | input | 1 | Shift engine is moving a byte |
| xfer_done | input | 1 | One-cycle pulse when a byte transfer ends |
| master_mode | input | 1 | Peripheral is configured as master |
| ss_is_input | input | 1 | Slave-select pin is configured as an input |
| ss_n | input | 1 | Slave-select pin level, active low |
| int_en | input | 1 | SPI interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | CPU acknowledges the SPI interrupt vector |
| stat_rdata | output | 8 | Status register read value |
| irq | output | 1 | Interrupt request |
| speed_double | output | 1 | Double-rate request to the clock divider |

## Verification
The assertions check some rules on every cycle. A flag can only be armed while it is set. A set event always leaves its flag at 1. An armed flag clears after a data access, and an unarmed flag survives one. The mode-fault pulse never lasts two cycles, and the double-speed bit changes only on a write. The bench's scenarios show how events combine over longer sequences: a flag that sets between the status read and the data access, a fault condition held low for several cycles, the acknowledge leaving the collision flag alone, and the exact read-back value after each step. A behavioural model is also compared with the outputs on every clock.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int REG_W   = 8;
  localparam int TC_BIT  = 7;
  localparam int WC_BIT  = 6;
  localparam int SPD_BIT = 0;
  localparam int NFLAG   = 2;
  localparam int FLAG_TC = 0;
  localparam int FLAG_WC = 1;
endpackage

// File: rtl/spi_mode_fault.sv
module spi_mode_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic master_i,
  input  logic ss_in_i,
  input  logic ss_n_i,
  output logic fault_o
);
  logic cond, cond_q;

  assign cond    = master_i & ss_in_i & ~ss_n_i;
  assign fault_o = cond & ~cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  AST_FAULT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o); // R4
endmodule

// File: rtl/spi_flag_cell.sv
module spi_flag_cell #(
  parameter bit HAS_ACK = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  input  logic stat_rd_i,
  input  logic access_i,
  output logic flag_o
);
  logic armed;
  logic ack_clr;
  logic clr;

  assign ack_clr = HAS_ACK & ack_i;
  assign clr     = (access_i & armed) | ack_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      armed  <= 1'b0;
    end else begin
      flag_o <= set_i | (flag_o & ~clr);
      if (clr)                     armed <= 1'b0;
      else if (stat_rd_i && flag_o) armed <= 1'b1;
    end
  end

  AST_ARMED_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> flag_o); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R8
  AST_ARMED_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (access_i && armed && !set_i) |=> !flag_o); // R6
  AST_UNARMED_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !armed && !ack_clr) |=> flag_o); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !set_i) |=> !flag_o); // R9
endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
#(
  parameter int W       = REG_W,
  parameter int TC_POS  = TC_BIT,
  parameter int WC_POS  = WC_BIT,
  parameter int SPD_POS = SPD_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stat_rd,
  input  logic         stat_wr,
  input  logic         wr_spd,
  input  logic         data_rd,
  input  logic         data_wr,
  input  logic         xfer_busy,
  input  logic         xfer_done,
  input  logic         master_mode,
  input  logic         ss_is_input,
  input  logic         ss_n,
  input  logic         int_en,
  input  logic         glob_ie,
  input  logic         irq_ack,
  output logic [W-1:0] stat_rdata,
  output logic         irq,
  output logic         speed_double
);
  localparam bit [NFLAG-1:0] ACK_MASK = NFLAG'(1) << FLAG_TC;

  logic             fault;
  logic             access;
  logic             spd_q;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] flags;

  assign access = data_rd | data_wr;

  spi_mode_fault u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .master_i (master_mode),
    .ss_in_i  (ss_is_input),
    .ss_n_i   (ss_n),
    .fault_o  (fault)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FLAG_TC] = xfer_done | fault;
    set_vec[FLAG_WC] = data_wr & xfer_busy;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    spi_flag_cell #(.HAS_ACK(ACK_MASK[g])) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_vec[g]),
      .ack_i     (irq_ack),
      .stat_rd_i (stat_rd),
      .access_i  (access),
      .flag_o    (flags[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       spd_q <= 1'b0;
    else if (stat_wr) spd_q <= wr_spd;
  end

  always_comb begin
    stat_rdata          = '0;
    stat_rdata[TC_POS]  = flags[FLAG_TC];
    stat_rdata[WC_POS]  = flags[FLAG_WC];
    stat_rdata[SPD_POS] = spd_q;
  end

  assign irq          = flags[FLAG_TC] & int_en & glob_ie;
  assign speed_double = spd_q & master_mode;

  AST_SPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> $stable(spd_q)); // R11
  AST_WCOL_IGNORES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !access && flags[FLAG_WC]) |=> flags[FLAG_WC]); // R9
  AST_DONE_SETS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> stat_rdata[TC_POS]); // R3
endmodule

// File: tb/spi_stat_ctrl_tb.sv
`timescale 1ns/1ps
module spi_stat_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_rd = 0, stat_wr = 0, wr_spd = 0, data_rd = 0, data_wr = 0;
  logic xfer_busy = 0, xfer_done = 0, master_mode = 0, ss_is_input = 0, ss_n = 1;
  logic int_en = 0, glob_ie = 0, irq_ack = 0;
  logic [7:0] stat_rdata;
  logic irq, speed_double;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_tc, m_wc, m_spd, m_tca, m_wca, m_fprev;

  always #2.5 clk = ~clk;

  spi_stat_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .stat_wr(stat_wr), .wr_spd(wr_spd),
    .data_rd(data_rd), .data_wr(data_wr), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
    .master_mode(master_mode), .ss_is_input(ss_is_input), .ss_n(ss_n),
    .int_en(int_en), .glob_ie(glob_ie), .irq_ack(irq_ack),
    .stat_rdata(stat_rdata), .irq(irq), .speed_double(speed_double)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tc = 0; m_wc = 0; m_spd = 0; m_tca = 0; m_wca = 0; m_fprev = 0;
    end else begin
      bit acc, flt, tc_set, tc_clr, wc_set, wc_clr;
      acc    = data_rd | data_wr;
      flt    = master_mode & ss_is_input & ~ss_n;
      tc_set = xfer_done | (flt & ~m_fprev);
      tc_clr = (acc & m_tca) | irq_ack;
      wc_set = data_wr & xfer_busy;
      wc_clr = acc & m_wca;
      if (tc_clr) m_tca = 0; else if (stat_rd && m_tc) m_tca = 1;
      if (wc_clr) m_wca = 0; else if (stat_rd && m_wc) m_wca = 1;
      m_tc = tc_set | (m_tc & ~tc_clr);
      m_wc = wc_set | (m_wc & ~wc_clr);
      if (stat_wr) m_spd = wr_spd;
      m_fprev = flt;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [7:0] exp_rd;
      exp_rd = {m_tc, m_wc, 5'b0, m_spd};
      checks++;
      if (stat_rdata !== exp_rd || irq !== (m_tc & int_en & glob_ie) ||
          speed_double !== (m_spd & master_mode)) begin
        errors++;
        $display("FAIL %s model: rd=%h irq=%b spd=%b expected rd=%h irq=%b spd=%b", cur_req,
                 stat_rdata, irq, speed_double, exp_rd, m_tc & int_en & glob_ie, m_spd & master_mode);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    stat_rd = 0; stat_wr = 0; data_rd = 0; data_wr = 0; xfer_done = 0; irq_ack = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    cur_req = "R1";
    chk("R1 rdata", stat_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 speed", {7'b0, speed_double}, 8'h00);

    cur_req = "R11"; wr_spd = 1; stat_wr = 1; step();
    chk("R2 layout spd only", stat_rdata, 8'h01);
    chk("R11 slave no double", {7'b0, speed_double}, 8'h00);
    master_mode = 1; #1;
    chk("R11 master double", {7'b0, speed_double}, 8'h01);
    step(); step();
    chk("R11 holds", stat_rdata, 8'h01);
    wr_spd = 0; stat_wr = 1; step();
    chk("R11 cleared", stat_rdata, 8'h00);
    master_mode = 0;

    cur_req = "R3"; xfer_done = 1; step();
    chk("R3 done sets", stat_rdata, 8'h80);
    cur_req = "R10"; int_en = 1; #1;
    chk("R10 no global", {7'b0, irq}, 8'h00);
    glob_ie = 1; #1;
    chk("R10 irq", {7'b0, irq}, 8'h01);
    int_en = 0; #1;
    chk("R10 no enable", {7'b0, irq}, 8'h00);

    cur_req = "R7"; data_rd = 1; step();
    chk("R7 unarmed access", stat_rdata, 8'h80);
    cur_req = "R6"; stat_rd = 1; step();
    data_rd = 1; step();
    chk("R6 two-step clear", stat_rdata, 8'h00);

    cur_req = "R5"; xfer_busy = 1; data_wr = 1; step();
    chk("R5 collision", stat_rdata, 8'h40);
    xfer_busy = 0; data_wr = 1; step();
    chk("R5 idle write no set", stat_rdata, 8'h40);
    xfer_done = 1; step();
    chk("R2 both flags", stat_rdata, 8'hC0);
    cur_req = "R6"; stat_rd = 1; step();
    data_wr = 1; step();
    chk("R6 both cleared by write", stat_rdata, 8'h00);

    cur_req = "R7"; xfer_done = 1; step();
    stat_rd = 1; step();
    xfer_busy = 1; data_wr = 1; step();
    chk("R7 late collision kept", stat_rdata, 8'h40);
    xfer_busy = 0; data_rd = 1; step();
    chk("R7 unarmed wcol survives", stat_rdata, 8'h40);
    stat_rd = 1; step(); data_rd = 1; step();
    chk("R6 wcol cleared", stat_rdata, 8'h00);

    cur_req = "R8"; xfer_done = 1; step();
    stat_rd = 1; step();
    xfer_done = 1; data_rd = 1; step();
    chk("R8 set wins", stat_rdata, 8'h80);
    data_rd = 1; step();
    chk("R8 disarmed", stat_rdata, 8'h80);
    xfer_done = 1; irq_ack = 1; step();
    chk("R8 set beats ack", stat_rdata, 8'h80);

    cur_req = "R9"; xfer_busy = 1; data_wr = 1; step();
    xfer_busy = 0;
    chk("R9 setup", stat_rdata, 8'hC0);
    irq_ack = 1; step();
    chk("R9 ack clears tc only", stat_rdata, 8'h40);
    stat_rd = 1; step(); data_rd = 1; step();
    chk("R9 cleanup", stat_rdata, 8'h00);

    cur_req = "R4"; master_mode = 1; ss_is_input = 0; ss_n = 0; step();
    chk("R4 output ss no fault", stat_rdata, 8'h00);
    ss_n = 1; step();
    ss_is_input = 1; ss_n = 0; step();
    chk("R4 fault sets", stat_rdata, 8'h80);
    stat_rd = 1; step(); data_rd = 1; step();
    step(); step();
    chk("R4 held low no reset", stat_rdata, 8'h00);
    ss_n = 1; step();
    ss_n = 0; step();
    chk("R4 second fault", stat_rdata, 8'h80);
    irq_ack = 1; step();
    chk("R9 ack clears fault flag", stat_rdata, 8'h00);
    master_mode = 0; ss_n = 1; step();
    ss_n = 0; step();
    chk("R4 slave no fault", stat_rdata, 8'h00);
    step();
    finish_run();
  end
endmodule